// File: doc/BRIEF.md
# Channel Address Deinterleave Unit

This block turns a system address into a dense address local to one memory channel. A request carries the system address, the index of the memory controller that owns it and the channel index inside that controller. The unit searches that controller's eight target ranges for one that covers the address. It subtracts the channel's offset for the range. It then removes two interleave levels, socket and channel, each with its own bit granularity and way count. The result is the address as the channel itself sees it.

Channel interleave may be three-way, so one removal step needs a true division. A single bit-serial divider is shared by both steps and is bypassed in one cycle when the way count is one. If the channel is three-way and its interleave bit sits below the socket interleave bit, the channel level is removed first. Range words are loaded through a simple write port. Requests and responses each use a valid/ready handshake, and only one request is in flight at a time.

Top module: `chan_deinterleave`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into the word selected by `cfg_kind`, taken at the clock edge. Code 0 stores the range base word and code 1 the range wayness word, both for (`cfg_ctrl`, `cfg_entry`). Code 2 stores the offset word for (`cfg_ctrl`, `cfg_chan`, `cfg_entry`). Code 3 changes nothing.
- R2: A range matches when base <= address <= limit. The base is base-word bits 31..12 shifted left by 26. The limit is wayness-word bits 31..12 shifted left by 26, with its low 26 bits set to one. When several ranges of the controller match, the lowest entry index wins.
- R3: If no range of the selected controller matches, the response carries `rsp_err`=1 and `rsp_addr`=0.
- R4: Before any interleave is removed, the channel offset (offset-word bits 23..4 shifted left by 26) is subtracted from the system address, modulo 2^ADDR_W.
- R5: Base-word bits 5..4 select the socket interleave bit position and bits 7..6 the channel position, with codes 0,1,2,3 meaning bits 6,8,12,30. The socket way count is 1 shifted left by wayness bits 11..10. The channel way count is wayness bits 9..8 plus one.
- R6: Removing one level at position p with w ways gives ((v >> p) / w) << p, ORed with the bits below p of a low-bit source. In the normal order the socket level is removed first, then the channel level, and both steps take their low bits from the original system address.
- R7: When the channel way count is 3 and the socket position is greater than the channel position, the channel level is removed first and then the socket level. Each step takes its low bits from the value it is working on.
- R8: `req_ready` is high only when no request is in flight, and the cycle after a request is accepted it is low. `rsp_valid`, `rsp_addr` and `rsp_err` hold steady until `rsp_ready` is seen. The unit is then idle again in the next cycle.
- R9: After reset `req_ready`=1 and `rsp_valid`=0, and every stored word is zero. Entry 0 then matches addresses below 2^26 with unit ways and zero offset, so such an address returns unchanged.
- R10: `rsp_valid` rises 5 clock edges after the accepting edge when both way counts are 1. Each level whose way count is not 1 adds ADDR_W edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Word kind: 0 base, 1 wayness, 2 offset, 3 none |
| cfg_ctrl | input | CTRL_W | Controller index of the write |
| cfg_chan | input | CHAN_W | Channel index (offset words only) |
| cfg_entry | input | ENT_W | Range entry index |
| cfg_data | input | 32 | Word written |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | System address |
| req_ctrl | input | CTRL_W | Selected controller |
| req_chan | input | CHAN_W | Selected channel |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | ADDR_W | Dense channel address |
| rsp_err | output | 1 | No range matched |

## Verification
The bound checker enforces the handshake rules on every cycle. It checks that only one request is in flight, that a pending response stays stable, that the idle and responding states never overlap, and that an error response always carries a zero address. The arithmetic needs the bench's scenarios. These cover the range priority, the offset subtraction, the two removal orders under every granularity and way combination, the preserved low bits and the cycle latency with and without the divider.

// File: rtl/chdi_pkg.sv
// Package: shared codes and helpers for the channel address deinterleave unit.
// Assumes range fields are 20 bits wide and sit 26 bits up in the address.
package chdi_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 20;
    localparam int RANGE_SH = 26;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_WAYS = 2'd1,
        CFG_OFFS = 2'd2,
        CFG_NONE = 2'd3
    } cfg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_STEP1,
        ST_STEP2,
        ST_RESP
    } state_e;

    // Map a 2-bit granularity code to an interleave bit position.
    function automatic logic [4:0] gran_pos(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd6;
            2'd1:    return 5'd8;
            2'd2:    return 5'd12;
            default: return 5'd30;
        endcase
    endfunction

endpackage

// File: rtl/chdi_range_table.sv
// Range table: holds base and wayness words per controller entry and
// offset words per controller, channel and entry. Looks up the lowest
// matching entry for the held request in one combinational pass.
// Assumes ADDR_W equals FIELD_W + RANGE_SH or more.
module chdi_range_table #(
    parameter int NUM_CTRL = 2,
    parameter int NUM_CHAN = 3,
    parameter int NUM_ENT  = 8,
    parameter int ADDR_W   = 46,
    localparam int CTRL_W  = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [CTRL_W-1:0] lk_ctrl,
    input  logic [CHAN_W-1:0] lk_chan,
    output logic              lk_hit,
    output logic [31:0]       lk_base,
    output logic [31:0]       lk_ways,
    output logic [31:0]       lk_offs
);
    import chdi_pkg::*;

    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << RANGE_SH) - 64'd1);

    logic [31:0] base_q [NUM_CTRL][NUM_ENT];
    logic [31:0] ways_q [NUM_CTRL][NUM_ENT];
    logic [31:0] offs_q [NUM_CTRL][NUM_CHAN][NUM_ENT];

    logic wr_ctrl_ok, wr_chan_ok, lk_chan_ok;
    assign wr_ctrl_ok = {1'b0, wr_ctrl} < (CTRL_W+1)'(NUM_CTRL);
    assign wr_chan_ok = {1'b0, wr_chan} < (CHAN_W+1)'(NUM_CHAN);
    assign lk_chan_ok = {1'b0, lk_chan} < (CHAN_W+1)'(NUM_CHAN);

    // Store configuration words; clear every word on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CTRL; c++) begin
                for (int e = 0; e < NUM_ENT; e++) begin
                    base_q[c][e] <= '0;
                    ways_q[c][e] <= '0;
                    for (int h = 0; h < NUM_CHAN; h++) offs_q[c][h][e] <= '0;
                end
            end
        end else if (wr_en && wr_ctrl_ok) begin
            case (cfg_kind_e'(wr_kind))
                CFG_BASE: base_q[wr_ctrl][wr_entry] <= wr_data;
                CFG_WAYS: ways_q[wr_ctrl][wr_entry] <= wr_data;
                CFG_OFFS: if (wr_chan_ok) offs_q[wr_ctrl][wr_chan][wr_entry] <= wr_data;
                default: ;
            endcase
        end
    end

    // Priority search: scan high to low so the lowest matching entry wins.
    always_comb begin
        lk_hit  = 1'b0;
        lk_base = '0;
        lk_ways = '0;
        lk_offs = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            logic [ADDR_W-1:0] lo, hi;
            lo = ADDR_W'(base_q[lk_ctrl][e][31:12]) << RANGE_SH;
            hi = (ADDR_W'(ways_q[lk_ctrl][e][31:12]) << RANGE_SH) | LOW_ONES;
            if (lo <= lk_addr && lk_addr <= hi) begin
                lk_hit  = 1'b1;
                lk_base = base_q[lk_ctrl][e];
                lk_ways = ways_q[lk_ctrl][e];
                lk_offs = lk_chan_ok ? offs_q[lk_ctrl][lk_chan][e] : '0;
            end
        end
    end

endmodule

// File: rtl/chdi_seq_div.sv
// Bit-serial restoring divider: one quotient bit per cycle, W cycles per
// division. A divisor of 1 is bypassed and finishes in a single cycle.
// Assumes the divisor is nonzero and start is only raised while idle.
module chdi_seq_div #(
    parameter int W     = 46,
    parameter int DIV_W = 4,
    localparam int REM_W = DIV_W + 1,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             done,
    output logic [W-1:0]     quotient
);
    logic [W-1:0]     quot_q;
    logic [REM_W-1:0] rem_q, rem_sh;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             fits;

    // Next partial remainder and whether the divisor fits into it.
    always_comb begin
        rem_sh = {rem_q[REM_W-2:0], quot_q[W-1]};
        fits   = rem_sh >= {1'b0, div_q};
    end

    // Iterate the division; pulse done when the quotient is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                quot_q <= dividend;
                rem_q  <= '0;
                div_q  <= divisor;
                if (divisor == DIV_W'(1)) begin
                    done <= 1'b1;
                end else begin
                    cnt_q  <= CNT_W'(W);
                    busy_q <= 1'b1;
                end
            end else if (busy_q) begin
                rem_q  <= fits ? rem_sh - {1'b0, div_q} : rem_sh;
                quot_q <= {quot_q[W-2:0], fits};
                cnt_q  <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quotient = quot_q;

endmodule

// File: rtl/chan_deinterleave.sv
// Channel address deinterleave: accepts one request, finds its range,
// subtracts the channel offset and removes socket and channel interleave
// in the order the range demands, using one shared divider.
// Assumes req_ctrl and req_chan are in range for the configured sizes.
module chan_deinterleave #(
    parameter int NUM_CTRL = 2,
    parameter int NUM_CHAN = 3,
    parameter int NUM_ENT  = 8,
    parameter int ADDR_W   = 46,
    localparam int CTRL_W  = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [ENT_W-1:0]  cfg_entry,
    input  logic [31:0]       cfg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic [CHAN_W-1:0] req_chan,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err
);
    import chdi_pkg::*;

    localparam int DIV_W = 4;

    state_e            state_q;
    logic [ADDR_W-1:0] addr_q, cur_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CHAN_W-1:0] chan_q;
    logic              err_q, issued_q, chf_q;
    logic [4:0]        pos1_q, pos2_q;
    logic [DIV_W-1:0]  ways1_q, ways2_q;

    logic              lk_hit;
    logic [31:0]       lk_base, lk_ways, lk_offs;

    chdi_range_table #(
        .NUM_CTRL(NUM_CTRL), .NUM_CHAN(NUM_CHAN),
        .NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_kind(cfg_kind), .wr_ctrl(cfg_ctrl),
        .wr_chan(cfg_chan), .wr_entry(cfg_entry), .wr_data(cfg_data),
        .lk_addr(addr_q), .lk_ctrl(ctrl_q), .lk_chan(chan_q),
        .lk_hit(lk_hit), .lk_base(lk_base), .lk_ways(lk_ways), .lk_offs(lk_offs)
    );

    // Decode the matched range into positions, ways and removal order.
    logic [4:0]        skt_pos, chn_pos;
    logic [DIV_W-1:0]  skt_ways, chn_ways;
    logic              chn_first;
    logic [ADDR_W-1:0] offs_val;
    always_comb begin
        skt_pos   = gran_pos(lk_base[5:4]);
        chn_pos   = gran_pos(lk_base[7:6]);
        skt_ways  = DIV_W'(1) << lk_ways[11:10];
        chn_ways  = DIV_W'(lk_ways[9:8]) + DIV_W'(1);
        chn_first = (chn_ways == DIV_W'(3)) && (skt_pos > chn_pos);
        offs_val  = ADDR_W'(lk_offs[23:4]) << RANGE_SH;
    end

    // Drive the shared divider for the current removal step.
    logic              step_act, div_start, div_done;
    logic [4:0]        pos_cur;
    logic [DIV_W-1:0]  ways_cur;
    logic [ADDR_W-1:0] div_quot, low_src, merged;
    always_comb begin
        step_act  = (state_q == ST_STEP1) || (state_q == ST_STEP2);
        div_start = step_act && !issued_q;
        pos_cur   = (state_q == ST_STEP1) ? pos1_q : pos2_q;
        ways_cur  = (state_q == ST_STEP1) ? ways1_q : ways2_q;
        low_src   = chf_q ? cur_q : addr_q;
        merged    = (div_quot << pos_cur) |
                    (low_src & ((ADDR_W'(1) << pos_cur) - ADDR_W'(1)));
    end

    chdi_seq_div #(.W(ADDR_W), .DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .start(div_start), .dividend(cur_q >> pos_cur), .divisor(ways_cur),
        .done(div_done), .quotient(div_quot)
    );

    // Request sequencer: accept, look up, two removal steps, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            cur_q    <= '0;
            ctrl_q   <= '0;
            chan_q   <= '0;
            err_q    <= 1'b0;
            issued_q <= 1'b0;
            chf_q    <= 1'b0;
            pos1_q   <= '0;
            pos2_q   <= '0;
            ways1_q  <= '0;
            ways2_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    ctrl_q  <= req_ctrl;
                    chan_q  <= req_chan;
                    err_q   <= 1'b0;
                    state_q <= ST_LOOK;
                end
                ST_LOOK: if (!lk_hit) begin
                    cur_q   <= '0;
                    err_q   <= 1'b1;
                    state_q <= ST_RESP;
                end else begin
                    cur_q   <= addr_q - offs_val;
                    chf_q   <= chn_first;
                    pos1_q  <= chn_first ? chn_pos  : skt_pos;
                    ways1_q <= chn_first ? chn_ways : skt_ways;
                    pos2_q  <= chn_first ? skt_pos  : chn_pos;
                    ways2_q <= chn_first ? skt_ways : chn_ways;
                    state_q <= ST_STEP1;
                end
                ST_STEP1, ST_STEP2: begin
                    if (!issued_q) begin
                        issued_q <= 1'b1;
                    end else if (div_done) begin
                        cur_q    <= merged;
                        issued_q <= 1'b0;
                        state_q  <= (state_q == ST_STEP1) ? ST_STEP2 : ST_RESP;
                    end
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_addr  = cur_q;
    assign rsp_err   = err_q;

endmodule

// File: rtl/chan_deinterleave_chk.sv
// Checker: handshake and error-response properties, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module chan_deinterleave_chk #(
    parameter int ADDR_W = 46
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_err
);
    // R8: an accepted request closes the input until it is answered.
    a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R8: a pending response holds its value until taken.
    a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err));

    // R8: idle and responding never overlap.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R8: a taken response returns the unit to idle.
    a_r8_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready && !rsp_valid);

    // R3: an error response carries a zero address.
    a_r3_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_addr == '0);
endmodule

bind chan_deinterleave chan_deinterleave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_err(rsp_err)
);

// File: tb/chan_deinterleave_tb_top.sv
// Bench: sweeps every granularity and way combination on one range and
// checks results, errors, priority and latency against an arithmetic model.
module chan_deinterleave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 46;
    localparam logic [63:0] AMASK = (64'd1 << ADDR_W) - 64'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_kind = '0;
    logic [0:0]        cfg_ctrl = '0;
    logic [1:0]        cfg_chan = '0;
    logic [2:0]        cfg_entry = '0;
    logic [31:0]       cfg_data = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [0:0]        req_ctrl = '0;
    logic [1:0]        req_chan = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [ADDR_W-1:0] rsp_addr;
    logic              rsp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_deinterleave dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_ctrl(cfg_ctrl),
        .cfg_chan(cfg_chan), .cfg_entry(cfg_entry), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_ctrl(req_ctrl), .req_chan(req_chan),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_err(rsp_err)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [31:0] sh_base [2][8];
    logic [31:0] sh_ways [2][8];
    logic [31:0] sh_offs [2][3][8];
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 180000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<180000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic int pos_of(input int code);
        case (code)
            0: return 6;
            1: return 8;
            2: return 12;
            default: return 30;
        endcase
    endfunction

    function automatic logic [63:0] remove_lvl(input logic [63:0] v, input int p, input int w, input logic [63:0] low);
        logic [63:0] m;
        m = (64'd1 << p) - 64'd1;
        return ((((v >> p) / w) << p) | (low & m)) & AMASK;
    endfunction

    // Reference model built from the requirements, using shadow config.
    task automatic model(input logic [63:0] a, input int c, input int h,
                         output bit err, output logic [63:0] res, output int ndiv, output bit chf);
        int hit;
        hit = -1;
        for (int e = 0; e < 8; e++) begin
            logic [63:0] lo, hi;
            lo = {44'd0, sh_base[c][e][31:12]} << 26;
            hi = ({44'd0, sh_ways[c][e][31:12]} << 26) | 64'h3FF_FFFF;
            if (hit < 0 && lo <= a && a <= hi) hit = e;
        end
        err = (hit < 0);
        res = 0;
        ndiv = 0;
        chf = 0;
        if (!err) begin
            int sp, cp, sw, cw;
            logic [63:0] ca, c1;
            sp = pos_of(int'(sh_base[c][hit][5:4]));
            cp = pos_of(int'(sh_base[c][hit][7:6]));
            sw = 1 << sh_ways[c][hit][11:10];
            cw = int'(sh_ways[c][hit][9:8]) + 1;
            ca = (a - ({44'd0, sh_offs[c][h][hit][23:4]} << 26)) & AMASK;
            chf = (cw == 3) && (sp > cp);
            if (chf) begin
                c1  = remove_lvl(ca, cp, cw, ca);
                res = remove_lvl(c1, sp, sw, c1);
            end else begin
                c1  = remove_lvl(ca, sp, sw, a);
                res = remove_lvl(c1, cp, cw, a);
            end
            ndiv = (sw != 1 ? 1 : 0) + (cw != 1 ? 1 : 0);
        end
    endtask

    task automatic cfg_write(input int kind, input int c, input int h, input int e, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_kind = 2'(kind);
        cfg_ctrl = 1'(c);
        cfg_chan = 2'(h);
        cfg_entry = 3'(e);
        cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind == 0) sh_base[c][e] = d;
        else if (kind == 1) sh_ways[c][e] = d;
        else if (kind == 2) sh_offs[c][h][e] = d;
    endtask

    function automatic logic [31:0] base_word(input int fld, input int sg, input int cg);
        return {20'(fld), 4'd0, 2'(cg), 2'(sg), 4'd0};
    endfunction
    function automatic logic [31:0] ways_word(input int fld, input int sw, input int cw);
        return {20'(fld), 2'(sw), 2'(cw), 8'd0};
    endfunction
    function automatic logic [31:0] offs_word(input int fld);
        return {8'd0, 20'(fld), 4'd0};
    endfunction

    // Issue one request and collect its response; returns edges to response.
    task automatic run(input logic [63:0] a, input int c, input int h, input int hold,
                       output logic [ADDR_W-1:0] got, output bit got_err, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a[ADDR_W-1:0];
        req_ctrl = 1'(c);
        req_chan = 2'(h);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        got = rsp_addr;
        got_err = rsp_err;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(rsp_valid && !req_ready && rsp_addr == got && rsp_err == got_err,
                  "R8 hold", {18'd0, rsp_addr}, {18'd0, got});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, "R8 idle after take", {63'd0, req_ready}, 64'd1);
    endtask

    // Run one request and compare it with the model under a requirement tag.
    task automatic run_check(input logic [63:0] a, input int c, input int h, input string tag, input bit chk_lat);
        logic [ADDR_W-1:0] got;
        bit got_err, e_err, chf;
        logic [63:0] e_res;
        int lat, ndiv;
        model(a, c, h, e_err, e_res, ndiv, chf);
        run(a, c, h, 0, got, got_err, lat);
        check(got_err == e_err, {tag, " err"}, {63'd0, got_err}, {63'd0, e_err});
        check({18'd0, got} == e_res, tag, {18'd0, got}, e_res);
        if (chk_lat)
            check(lat == 5 + ADDR_W * ndiv, "R10 latency", 64'(lat), 64'(5 + ADDR_W * ndiv));
    endtask

    initial begin
        logic [ADDR_W-1:0] got;
        bit got_err;
        int lat;
        for (int c = 0; c < 2; c++)
            for (int e = 0; e < 8; e++) begin
                sh_base[c][e] = '0;
                sh_ways[c][e] = '0;
                for (int h = 0; h < 3; h++) sh_offs[c][h][e] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state and default entry 0 pass-through.
        check(req_ready == 1'b1, "R9 req_ready", {63'd0, req_ready}, 64'd1);
        check(rsp_valid == 1'b0, "R9 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        run(64'h123_4567, 1, 2, 0, got, got_err, lat);
        check({18'd0, got} == 64'h123_4567 && !got_err, "R9 passthrough", {18'd0, got}, 64'h123_4567);
        check(lat == 5, "R10 unit latency", 64'(lat), 64'd5);

        // R3: no matching range on controller 1.
        run_check(64'd5 << 26, 1, 0, "R3 miss", 1'b0);

        // R4: offset subtraction per channel with unit ways.
        cfg_write(0, 0, 0, 3, base_word(1, 2, 1));
        cfg_write(1, 0, 0, 3, ways_word(20'hFFFFF, 0, 0));
        for (int h = 0; h < 3; h++) cfg_write(2, 0, h, 3, offs_word(h * 5 + 1));
        for (int h = 0; h < 3; h++) run_check((64'd1 << 40) | 64'h0ABC_DEF1_2345, 0, h, "R4 offset", 1'b1);

        // R8: response held across idle rsp_ready cycles.
        run(64'd1 << 41, 0, 1, 3, got, got_err, lat);

        // R5, R6, R7: sweep every granularity and way code on entry 3.
        for (int sg = 0; sg < 4; sg++)
            for (int cg = 0; cg < 4; cg++)
                for (int sw = 0; sw < 4; sw++)
                    for (int cw = 0; cw < 4; cw++) begin
                        string tag;
                        cfg_write(0, 0, 0, 3, base_word(1, sg, cg));
                        cfg_write(1, 0, 0, 3, ways_word(20'hFFFFF, sw, cw));
                        tag = (cw == 2 && pos_of(sg) > pos_of(cg)) ? "R7 chan-first" : "R6 skt-first";
                        for (int n = 0; n < 2; n++) begin
                            logic [63:0] a;
                            a = (next_rand() & AMASK) | (64'd1 << 40);
                            run_check(a, 0, (sg + cw + n) % 3, tag, (sg == 0 && cg == 0 && n == 0));
                        end
                    end

        // R2: overlapping ranges on controller 1, lowest index wins.
        cfg_write(0, 1, 0, 2, base_word(10, 1, 0));
        cfg_write(1, 1, 0, 2, ways_word(20, 1, 2));
        cfg_write(0, 1, 0, 5, base_word(12, 0, 3));
        cfg_write(1, 1, 0, 5, ways_word(30, 2, 1));
        run_check((64'd15 << 26) | 64'h12_3456, 1, 0, "R2 priority low", 1'b1);
        run_check((64'd25 << 26) | 64'h2F_0F0F, 1, 0, "R2 upper range", 1'b1);
        run_check(64'd40 << 26, 1, 0, "R3 above all", 1'b0);

        // R1: a code-3 write changes nothing.
        cfg_write(3, 1, 0, 2, base_word(20'hFFFFF, 3, 3));
        run_check((64'd15 << 26) | 64'h12_3456, 1, 0, "R1 ignored kind", 1'b0);
        cfg_write(3, 1, 0, 0, ways_word(20'h1, 0, 0));
        run_check(64'd1 << 26, 1, 0, "R1 ignored kind miss", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule